// File: doc/BRIEF.md
# Operand Bypass and Decode Stall Resolver

This combinational block sits beside the decode stage of an in-order pipeline. The pipeline runs fetch, decode, up to three execute steps, a memory step and writeback. The instruction in decode names up to two source registers. Each in-flight older instruction reports, per stage, four things: its destination register, whether it writes that register at all, whether it is a load still waiting for its data, and its execute-latency class. Each stage also offers its current result. For each source, the block picks one of three outcomes. It may bypass the value of the nearest matching producer. It may take the register-file read. Or it raises a stall when the matching producer cannot yet supply the value.

A producer's result is not ready just because it is some distance ahead. Readiness depends on how many execute steps the producer needs. It also depends on whether the consumer resolves its operands in decode: a zero-latency consumer such as a branch needs the value one step earlier. The block also decides control transfer. A jump, or a branch whose resolved operands satisfy its condition, asserts a redirect. The surrounding pipeline uses it to load the new fetch address and squash the fetched instruction.

Top module: `fwd_stall_unit`

## Requirements
- R1: Latency classes are 2-bit values 0 to 3, and the consumer counts as zero-stage (z=1) when `dec_lat` is 0. A matching producer at stage index 0 (the stage right after decode) is forwarded only when its latency is at most 1-z and its pending-load flag is clear; otherwise `stall` is raised.
- R2: A matching producer at stage index 1 is forwarded only when its latency is at most 2-z and its pending-load flag is clear; otherwise `stall` is raised.
- R3: A matching producer at stage index 2 or 3 is forwarded unless its pending-load flag is set, in which case `stall` is raised; latency plays no part.
- R4: A matching producer at stage index 4 (after memory) is always forwarded, even with its pending-load flag set.
- R5: A used source that matches no stage takes the register-file value (`rf_a` / `rf_b`) and causes no stall.
- R6: When several stages match one source, only the lowest stage index decides whether that source forwards or stalls.
- R7: A stage matches a source only when its write-valid bit is set and its destination equals the source number; a stage with the write-valid bit clear is ignored whatever its register number.
- R8: A source whose use flag is clear never causes a stall, and its operand output carries the register-file value.
- R9: `stall` is the OR of the two per-source stall conditions; either source alone can raise it.
- R10: `dec_kind` encodes 0 = no transfer, 1 = jump, 2 = branch-if-equal, 3 = branch-if-not-equal. `redirect` is 1 for a jump, and for a branch whose resolved operands `opnd_a`/`opnd_b` meet its condition.
- R11: `redirect` is 0 whenever `stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_AW | First source register number of the decode instruction |
| dec_src_b | input | REG_AW | Second source register number of the decode instruction |
| dec_use_a | input | 1 | First source is needed |
| dec_use_b | input | 1 | Second source is needed |
| dec_lat | input | 2 | Execute-latency class of the decode instruction |
| dec_kind | input | 2 | Control-transfer kind of the decode instruction |
| rf_a | input | DATA_W | Register-file read for the first source |
| rf_b | input | DATA_W | Register-file read for the second source |
| st_dst | input | STAGES*REG_AW | Destination number per stage, stage 0 in the low slice |
| st_wr | input | STAGES | Write-valid bit per stage |
| st_ldp | input | STAGES | Load-awaiting-data bit per stage |
| st_lat | input | STAGES*2 | Latency class per stage |
| st_res | input | STAGES*DATA_W | Current result value per stage |
| opnd_a | output | DATA_W | Resolved first operand |
| opnd_b | output | DATA_W | Resolved second operand |
| stall | output | 1 | Hold decode this cycle |
| redirect | output | 1 | Control transfer taken; squash fetch and reload the address |

## Verification
The bench uses the default parameters: five producer stages, 32-bit data, 5-bit register numbers, and latency checks on the first two stages. These values cover every stage rule. They reach both latency thresholds for both the zero-stage and the normal consumer, the pending-load cases in the middle stages, and the final stage that always forwards. With five stages, the bench can set several stages to the same register and show that the nearest one decides. Branch outcomes are checked with operands that come through the bypass, so any selection error shows up in `redirect`.

// File: rtl/fwd_pkg.sv
// Shared constants and encodings for the operand bypass resolver.
package fwd_pkg;
    localparam int LAT_W = 2;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_JUMP = 2'd1,
        XFER_BEQ  = 2'd2,
        XFER_BNE  = 2'd3
    } xfer_kind_e;
endpackage

// File: rtl/fwd_stage_match.sv
// Compares one source register against one in-flight stage.
// hit: the stage writes the same register. ok: its value may be bypassed now.
// Assumes stage index 0 is the stage directly after decode.
module fwd_stage_match
    import fwd_pkg::*;
#(
    parameter int REG_AW     = 5,
    parameter int STAGES     = 5,
    parameter int STAGE_IDX  = 0,
    parameter int LAT_STAGES = 2
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wr,
    input  logic              ldp,
    input  logic [LAT_W-1:0]  lat,
    input  logic              zero_cons,
    output logic              hit,
    output logic              ok
);
    localparam int LIM_W = LAT_W + 2;

    // Match requires a real write to the same register.
    always_comb hit = wr && (dst == src);

    generate
        if (STAGE_IDX < LAT_STAGES) begin : g_lat_check
            logic [LIM_W-1:0] limit;
            // Producer must finish within the steps left before the consumer needs it.
            always_comb begin
                limit = LIM_W'(STAGE_IDX + 1) - LIM_W'(zero_cons);
                ok    = (LIM_W'(lat) <= limit) && !ldp;
            end
        end else if (STAGE_IDX == STAGES - 1) begin : g_always
            // Past memory the value is final.
            always_comb ok = 1'b1;
        end else begin : g_load_check
            // Only a load still waiting for data blocks forwarding here.
            always_comb ok = !ldp;
        end
    endgenerate
endmodule

// File: rtl/fwd_operand_sel.sv
// Resolves one decode source: nearest matching stage decides bypass or stall,
// otherwise the register-file value is used. An unused source never stalls.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REG_AW     = 5,
    parameter int STAGES     = 5,
    parameter int LAT_STAGES = 2
) (
    input  logic [REG_AW-1:0]        src,
    input  logic                     use_src,
    input  logic                     zero_cons,
    input  logic [DATA_W-1:0]        rf_val,
    input  logic [STAGES*REG_AW-1:0] st_dst,
    input  logic [STAGES-1:0]        st_wr,
    input  logic [STAGES-1:0]        st_ldp,
    input  logic [STAGES*LAT_W-1:0]  st_lat,
    input  logic [STAGES*DATA_W-1:0] st_res,
    output logic [DATA_W-1:0]        value,
    output logic                     stall
);
    logic [STAGES-1:0] hit;
    logic [STAGES-1:0] ok;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            fwd_stage_match #(
                .REG_AW(REG_AW), .STAGES(STAGES),
                .STAGE_IDX(k), .LAT_STAGES(LAT_STAGES)
            ) match_i (
                .src       (src),
                .dst       (st_dst[k*REG_AW +: REG_AW]),
                .wr        (st_wr[k]),
                .ldp       (st_ldp[k]),
                .lat       (st_lat[k*LAT_W +: LAT_W]),
                .zero_cons (zero_cons),
                .hit       (hit[k]),
                .ok        (ok[k])
            );
        end
    endgenerate

    // Priority scan from the nearest stage; first hit decides.
    always_comb begin
        logic found;
        found = 1'b0;
        value = rf_val;
        stall = 1'b0;
        for (int k = 0; k < STAGES; k++) begin
            if (!found && hit[k]) begin
                found = 1'b1;
                if (ok[k]) value = st_res[k*DATA_W +: DATA_W];
                else       stall = 1'b1;
            end
        end
        if (!use_src) begin
            value = rf_val;
            stall = 1'b0;
        end
    end
endmodule

// File: rtl/fwd_branch_resolve.sv
// Decides control transfer in decode from the resolved operands.
// Assumes operands are valid only when no stall is raised.
module fwd_branch_resolve
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              stall,
    output logic              redirect
);
    // Evaluate the transfer condition, suppressed while decode is held.
    always_comb begin
        unique case (xfer_kind_e'(kind))
            XFER_JUMP: redirect = 1'b1;
            XFER_BEQ:  redirect = (a == b);
            XFER_BNE:  redirect = (a != b);
            default:   redirect = 1'b0;
        endcase
        if (stall) redirect = 1'b0;
    end
endmodule

// File: rtl/fwd_stall_unit.sv
// Top of the decode bypass and stall resolver. Purely combinational.
// Stage slice 0 of every per-stage bus is the stage right after decode;
// slice STAGES-1 is the stage after memory.
module fwd_stall_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REG_AW     = 5,
    parameter int STAGES     = 5,
    parameter int LAT_STAGES = 2
) (
    input  logic [REG_AW-1:0]        dec_src_a,
    input  logic [REG_AW-1:0]        dec_src_b,
    input  logic                     dec_use_a,
    input  logic                     dec_use_b,
    input  logic [LAT_W-1:0]         dec_lat,
    input  logic [1:0]               dec_kind,
    input  logic [DATA_W-1:0]        rf_a,
    input  logic [DATA_W-1:0]        rf_b,
    input  logic [STAGES*REG_AW-1:0] st_dst,
    input  logic [STAGES-1:0]        st_wr,
    input  logic [STAGES-1:0]        st_ldp,
    input  logic [STAGES*LAT_W-1:0]  st_lat,
    input  logic [STAGES*DATA_W-1:0] st_res,
    output logic [DATA_W-1:0]        opnd_a,
    output logic [DATA_W-1:0]        opnd_b,
    output logic                     stall,
    output logic                     redirect
);
    logic zero_cons;
    logic stall_a;
    logic stall_b;

    // A consumer with no execute step needs its operands in decode.
    always_comb zero_cons = (dec_lat == '0);

    fwd_operand_sel #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .STAGES(STAGES), .LAT_STAGES(LAT_STAGES)
    ) sel_a_i (
        .src(dec_src_a), .use_src(dec_use_a), .zero_cons(zero_cons), .rf_val(rf_a),
        .st_dst(st_dst), .st_wr(st_wr), .st_ldp(st_ldp), .st_lat(st_lat),
        .st_res(st_res), .value(opnd_a), .stall(stall_a)
    );

    fwd_operand_sel #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .STAGES(STAGES), .LAT_STAGES(LAT_STAGES)
    ) sel_b_i (
        .src(dec_src_b), .use_src(dec_use_b), .zero_cons(zero_cons), .rf_val(rf_b),
        .st_dst(st_dst), .st_wr(st_wr), .st_ldp(st_ldp), .st_lat(st_lat),
        .st_res(st_res), .value(opnd_b), .stall(stall_b)
    );

    // Either unresolved source holds decode.
    always_comb stall = stall_a | stall_b;

    fwd_branch_resolve #(.DATA_W(DATA_W)) br_i (
        .kind(dec_kind), .a(opnd_a), .b(opnd_b), .stall(stall), .redirect(redirect)
    );
endmodule

// File: rtl/fwd_stall_unit_chk.sv
// Property checker for fwd_stall_unit; immediate checks on the settled outputs.
module fwd_stall_unit_chk
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 5
) (
    input logic                 dec_use_a,
    input logic                 dec_use_b,
    input logic [DATA_W-1:0]    rf_a,
    input logic [DATA_W-1:0]    opnd_a,
    input logic [STAGES-1:0]    st_wr,
    input logic                 stall,
    input logic                 redirect
);
    // Check the output relations whenever inputs settle.
    always_comb begin
        if (!dec_use_a && !dec_use_b)
            assert_unused_no_stall_R8: assert (!stall);
        if (st_wr == '0)
            assert_nomatch_rf_R5: assert (!stall && opnd_a == rf_a);
        if (st_wr == STAGES'(1) << (STAGES - 1))
            assert_last_stage_forwards_R4: assert (!stall);
        if (stall)
            assert_no_redirect_on_stall_R11: assert (!redirect);
    end
endmodule

bind fwd_stall_unit fwd_stall_unit_chk #(.DATA_W(DATA_W), .STAGES(STAGES)) chk_i (
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b), .rf_a(rf_a), .opnd_a(opnd_a),
    .st_wr(st_wr), .stall(stall), .redirect(redirect)
);

// File: tb/fwd_stall_unit_tb.sv
// Directed bench for fwd_stall_unit: one task per scenario.
module fwd_stall_unit_tb_top;
    localparam int DATA_W = 32;
    localparam int REG_AW = 5;
    localparam int STAGES = 5;
    localparam logic [DATA_W-1:0] RFA = 32'hAAAA_0000;
    localparam logic [DATA_W-1:0] RFB = 32'hBBBB_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [REG_AW-1:0] dec_src_a, dec_src_b;
    logic dec_use_a, dec_use_b;
    logic [1:0] dec_lat, dec_kind;
    logic [DATA_W-1:0] rf_a, rf_b;
    logic [REG_AW-1:0] s_dst [STAGES];
    logic s_wr [STAGES];
    logic s_ldp [STAGES];
    logic [1:0] s_lat [STAGES];
    logic [DATA_W-1:0] s_res [STAGES];
    logic [STAGES*REG_AW-1:0] st_dst;
    logic [STAGES-1:0] st_wr, st_ldp;
    logic [STAGES*2-1:0] st_lat;
    logic [STAGES*DATA_W-1:0] st_res;
    logic [DATA_W-1:0] opnd_a, opnd_b;
    logic stall, redirect;

    always_comb begin
        for (int k = 0; k < STAGES; k++) begin
            st_dst[k*REG_AW +: REG_AW] = s_dst[k];
            st_wr[k] = s_wr[k];
            st_ldp[k] = s_ldp[k];
            st_lat[k*2 +: 2] = s_lat[k];
            st_res[k*DATA_W +: DATA_W] = s_res[k];
        end
    end

    fwd_stall_unit dut_i (
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_use_a(dec_use_a),
        .dec_use_b(dec_use_b), .dec_lat(dec_lat), .dec_kind(dec_kind),
        .rf_a(rf_a), .rf_b(rf_b), .st_dst(st_dst), .st_wr(st_wr),
        .st_ldp(st_ldp), .st_lat(st_lat), .st_res(st_res),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall), .redirect(redirect)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Idle pipeline, normal two-source consumer.
    task automatic clear_all();
        @(posedge clk);
        for (int k = 0; k < STAGES; k++) begin
            s_dst[k] = REG_AW'(k + 20); s_wr[k] = 1'b0; s_ldp[k] = 1'b0;
            s_lat[k] = 2'd1; s_res[k] = 32'h1000 + DATA_W'(k);
        end
        dec_src_a = 5'd3; dec_src_b = 5'd7; dec_use_a = 1'b1; dec_use_b = 1'b1;
        dec_lat = 2'd1; dec_kind = 2'd0; rf_a = RFA; rf_b = RFB;
    endtask

    task automatic set_st(input int k, input logic [4:0] d, input logic [1:0] l, input logic ldp);
        s_dst[k] = d; s_wr[k] = 1'b1; s_lat[k] = l; s_ldp[k] = ldp;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_idle();
        clear_all(); settle();
        chk("R5 idle opnd_a", opnd_a, RFA);
        chk("R5 idle opnd_b", opnd_b, RFB);
        chk("R5 idle stall", 32'(stall), 0);
        chk("R10 idle redirect", 32'(redirect), 0);
    endtask

    task automatic t_stage0();
        clear_all(); set_st(0, 5'd3, 2'd1, 1'b0); settle();
        chk("R1 lat1 normal fwd", opnd_a, 32'h1000);
        chk("R1 lat1 normal stall", 32'(stall), 0);
        dec_lat = 2'd0; settle();
        chk("R1 lat1 zero-stage stall", 32'(stall), 1);
        clear_all(); dec_lat = 2'd0; set_st(0, 5'd3, 2'd0, 1'b0); settle();
        chk("R1 lat0 zero-stage fwd", opnd_a, 32'h1000);
        clear_all(); set_st(0, 5'd3, 2'd2, 1'b0); settle();
        chk("R1 lat2 stall", 32'(stall), 1);
        clear_all(); set_st(0, 5'd3, 2'd1, 1'b1); settle();
        chk("R1 pending load stall", 32'(stall), 1);
    endtask

    task automatic t_stage1();
        clear_all(); set_st(1, 5'd3, 2'd2, 1'b0); settle();
        chk("R2 lat2 normal fwd", opnd_a, 32'h1001);
        chk("R2 lat2 normal stall", 32'(stall), 0);
        dec_lat = 2'd0; settle();
        chk("R2 lat2 zero-stage stall", 32'(stall), 1);
        s_lat[1] = 2'd1; settle();
        chk("R2 lat1 zero-stage fwd", opnd_a, 32'h1001);
        clear_all(); set_st(1, 5'd3, 2'd3, 1'b0); settle();
        chk("R2 lat3 stall", 32'(stall), 1);
        clear_all(); set_st(1, 5'd3, 2'd1, 1'b1); settle();
        chk("R2 pending load stall", 32'(stall), 1);
    endtask

    task automatic t_mid();
        clear_all(); set_st(2, 5'd3, 2'd3, 1'b0); dec_lat = 2'd0; settle();
        chk("R3 stage2 lat3 fwd", opnd_a, 32'h1002);
        chk("R3 stage2 no stall", 32'(stall), 0);
        s_ldp[2] = 1'b1; settle();
        chk("R3 stage2 pending stall", 32'(stall), 1);
        clear_all(); set_st(3, 5'd3, 2'd1, 1'b1); settle();
        chk("R3 stage3 pending stall", 32'(stall), 1);
        s_ldp[3] = 1'b0; settle();
        chk("R3 stage3 fwd", opnd_a, 32'h1003);
    endtask

    task automatic t_last();
        clear_all(); set_st(4, 5'd3, 2'd1, 1'b1); dec_lat = 2'd0; settle();
        chk("R4 last stage fwd", opnd_a, 32'h1004);
        chk("R4 last stage no stall", 32'(stall), 0);
    endtask

    task automatic t_priority();
        clear_all(); set_st(1, 5'd3, 2'd1, 1'b0); set_st(3, 5'd3, 2'd1, 1'b0); settle();
        chk("R6 nearest value", opnd_a, 32'h1001);
        clear_all(); set_st(0, 5'd3, 2'd3, 1'b0); set_st(4, 5'd3, 2'd1, 1'b0); settle();
        chk("R6 nearest stalls", 32'(stall), 1);
        clear_all(); set_st(0, 5'd9, 2'd3, 1'b0); set_st(2, 5'd3, 2'd1, 1'b0); settle();
        chk("R6 other reg skipped", opnd_a, 32'h1002);
    endtask

    task automatic t_write_valid();
        clear_all(); s_dst[0] = 5'd3; s_lat[0] = 2'd3; s_wr[0] = 1'b0; settle();
        chk("R7 no write no match stall", 32'(stall), 0);
        chk("R7 no write rf value", opnd_a, RFA);
    endtask

    task automatic t_unused();
        clear_all(); set_st(0, 5'd3, 2'd3, 1'b0); dec_use_a = 1'b0; settle();
        chk("R8 unused no stall", 32'(stall), 0);
        chk("R8 unused rf value", opnd_a, RFA);
    endtask

    task automatic t_or();
        clear_all(); set_st(0, 5'd7, 2'd3, 1'b0); settle();
        chk("R9 src b alone stalls", 32'(stall), 1);
        chk("R9 src a still rf", opnd_a, RFA);
    endtask

    task automatic t_redirect();
        clear_all(); dec_use_a = 1'b0; dec_use_b = 1'b0; dec_lat = 2'd0; dec_kind = 2'd1; settle();
        chk("R10 jump", 32'(redirect), 1);
        clear_all(); dec_lat = 2'd0; dec_kind = 2'd2; settle();
        chk("R10 beq unequal", 32'(redirect), 0);
        set_st(4, 5'd3, 2'd1, 1'b0); s_res[4] = RFB; settle();
        chk("R10 beq equal via bypass", 32'(redirect), 1);
        dec_kind = 2'd3; settle();
        chk("R10 bne equal", 32'(redirect), 0);
        clear_all(); dec_lat = 2'd0; dec_kind = 2'd3; settle();
        chk("R10 bne unequal", 32'(redirect), 1);
        set_st(0, 5'd7, 2'd1, 1'b0); settle();
        chk("R11 stall blocks redirect", 32'(redirect), 0);
        chk("R11 stall raised", 32'(stall), 1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_stage0();
        t_stage1();
        t_mid();
        t_last();
        t_priority();
        t_write_valid();
        t_unused();
        t_or();
        t_redirect();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule